// File: doc/BRIEF.md
# Skip-Chain Slot Activation Sequencer

The sequencer walks a fixed chain of `N` links in index order and emits a one-hot, one-cycle strobe for each link it fires. Each link stores two bits: an enable bit, which says whether the link's slot takes part in the run, and a pending bit, which says whether the link still has to fire in the current pass. No program counter and no address decoder pick the next slot. A combinational skip chain finds the lowest-index link that is both enabled and pending, and it passes over any run of disabled links inside the same cycle.

Software first sets a boundary index and loads the enable bits through a masked parallel write. The write only reaches links at or below the boundary. It then sets the run bit and issues a start command, which marks every link pending. Each step request then fires one enabled link and clears that link's pending bit. When no enabled link is still pending, `done` goes high. A further start command re-arms the chain for another pass.

Top module: `skip_chain_seq`

## Requirements
- R1: After reset all enable, pending and run bits are 0, the boundary index is N-1, `act` is all zeros and `done` is 1.
- R2: When `fill_we` is high and the chain is not active, the enable bit of every link whose index is at or below the stored boundary takes the matching bit of `fill_mask` at the clock edge. Links above the boundary keep their enable bits. A fill in the same cycle as a boundary write uses the old boundary.
- R3: When `last_we` is high and the chain is not active, the boundary index takes `last_idx` at the clock edge.
- R4: `start` sets the pending bit of every link to 1 only while the run bit is 1. With the run bit at 0 it has no effect. `run_set` sets the run bit and `run_clr` clears it, and `run_set` wins if both are high.
- R5: A `step` pulse sampled at one clock edge makes `act` equal, during the following cycle, to the one-hot code of the lowest-index link whose enable and pending bits are both 1, provided the run bit is 1. At the next edge that link's pending bit is cleared, unless `start` is applied at that same edge, in which case `start` wins.
- R6: Disabled links are passed over inside that same cycle, however many there are in a row. A disabled link keeps its pending bit and never appears in `act`.
- R7: `done` is 1 exactly when no link has both enable and pending set. A step request while `done` is 1 gives an all-zero `act`.
- R8: The chain is active when the run bit is 1 and `done` is 0. While it is active, `fill_we` and `last_we` are ignored.
- R9: After the chain has finished, a new `start` re-arms every link, and the enabled links fire again in the same order.
- R10: `act` has at most one bit set, and it is nonzero only in the cycle that follows a sampled step request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_we | input | 1 | Write the enable bits from `fill_mask` |
| fill_mask | input | N | New enable values, one bit per link |
| last_we | input | 1 | Load the boundary index |
| last_idx | input | $clog2(N) | Highest link index a fill may write |
| run_set | input | 1 | Set the run bit |
| run_clr | input | 1 | Clear the run bit |
| start | input | 1 | Mark every link pending (run bit must be 1) |
| step | input | 1 | Step request; fires the next enabled, pending link |
| act | output | N | One-hot slot activation strobe |
| done | output | 1 | No enabled link is still pending |

## Verification
The bench targets the cases that break a skip chain. It uses long gaps of disabled links, so a design that stepped one link per request would stay silent where a strobe is due. It sends step requests after the chain has finished, so a design that wrapped around or fired a stale link would strobe when it should stay quiet. It writes fills and boundary changes during a run, so a design that took them would fire links that were never loaded. It issues a start with the run bit clear and a fill above the boundary, so a design that ignored either gate would arm the chain or enable links it must not touch. Back-to-back steps and a restart after completion show whether pending bits are cleared and re-armed at the right edge.

// File: rtl/skip_chain_seq.sv
module skip_chain_seq #(
  parameter int N = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fill_we,
  input  logic [N-1:0]  fill_mask,
  input  logic          last_we,
  input  logic [IW-1:0] last_idx,
  input  logic          run_set,
  input  logic          run_clr,
  input  logic          start,
  input  logic          step,
  output logic [N-1:0]  act,
  output logic          done
);

  logic [N-1:0]  en_q, pend_q, ready, seen, pick, reach;
  logic [IW-1:0] last_q;
  logic          run_q, step_q, active;

  assign ready  = en_q & pend_q;
  assign done   = ~|ready;
  assign active = run_q & ~done;

  // skip chain: a link fires only if no lower link is ready
  for (genvar i = 0; i < N; i++) begin : g_link
    if (i == 0) begin : g_head
      assign seen[i] = 1'b0;
    end else begin : g_body
      assign seen[i] = seen[i-1] | ready[i-1];
    end
    assign pick[i]  = ready[i] & ~seen[i];
    assign reach[i] = (IW'(i) <= last_q);
  end

  assign act = (step_q && run_q) ? pick : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
      run_q  <= 1'b0;
      step_q <= 1'b0;
      last_q <= IW'(N - 1);
    end else begin
      step_q <= step;
      if (run_set)      run_q <= 1'b1;
      else if (run_clr) run_q <= 1'b0;
      if (last_we && !active) last_q <= last_idx;
      if (fill_we && !active) en_q <= (en_q & ~reach) | (fill_mask & reach);
      if (start && run_q) pend_q <= '1;
      else                pend_q <= pend_q & ~act;
    end
  end

  AST_ACT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act)); // R10
  AST_ACT_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (act != '0) |-> $past(step)); // R10
  AST_FIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((act != '0) && !start) |=> ((pend_q & $past(act)) == '0)); // R5
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (act == '0)); // R7
  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && run_q) |=> (pend_q == '1)); // R4
  AST_FILL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_we && active) |=> $stable(en_q)); // R8

endmodule

// File: tb/test_skip_chain_seq.sv
module test_skip_chain_seq;
  localparam int N  = 16;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fill_we = 0, last_we = 0, run_set = 0, run_clr = 0, start = 0, step = 0;
  logic [N-1:0] fill_mask = '0;
  logic [IW-1:0] last_idx = '0;
  logic [N-1:0] act;
  logic done;

  always #4 clk = ~clk;

  skip_chain_seq #(.N(N)) i_skip_chain_seq (
    .clk(clk), .rst_n(rst_n), .fill_we(fill_we), .fill_mask(fill_mask),
    .last_we(last_we), .last_idx(last_idx), .run_set(run_set), .run_clr(run_clr),
    .start(start), .step(step), .act(act), .done(done));

  int errors = 0, checks = 0;
  bit m_en[N], m_pend[N];
  bit m_run, m_step;
  int m_last;

  function automatic bit m_ready_any();
    for (int i = 0; i < N; i++) if (m_en[i] && m_pend[i]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [N-1:0] m_act();
    logic [N-1:0] r = '0;
    if (m_step && m_run)
      for (int i = 0; i < N; i++)
        if (m_en[i] && m_pend[i]) begin r[i] = 1'b1; break; end
    return r;
  endfunction

  task automatic check(input string tag);
    logic [N-1:0] ea = m_act();
    logic ed = !m_ready_any();
    checks++;
    if (act !== ea) begin
      errors++;
      $display("FAIL %s R5/R6/R10 act=%h expected %h", tag, act, ea);
    end
    checks++;
    if (done !== ed) begin
      errors++;
      $display("FAIL %s R7 done=%b expected %b", tag, done, ed);
    end
  endtask

  task automatic tick(input string tag, input logic fw, input logic [N-1:0] fm,
                      input logic lw, input int li, input logic rs, input logic rc,
                      input logic st, input logic sp);
    logic [N-1:0] fired;
    bit act_now;
    fill_we = fw; fill_mask = fm; last_we = lw; last_idx = IW'(li);
    run_set = rs; run_clr = rc; start = st; step = sp;
    @(posedge clk);
    fired = m_act();
    act_now = m_run && m_ready_any();
    if (fw && !act_now)
      for (int i = 0; i < N; i++) if (i <= m_last) m_en[i] = fm[i];
    if (lw && !act_now) m_last = li;
    if (st && m_run) for (int i = 0; i < N; i++) m_pend[i] = 1'b1;
    else             for (int i = 0; i < N; i++) if (fired[i]) m_pend[i] = 1'b0;
    if (rs) m_run = 1'b1; else if (rc) m_run = 1'b0;
    m_step = sp;
    @(negedge clk);
    fill_we = 0; last_we = 0; run_set = 0; run_clr = 0; start = 0; step = 0;
    check(tag);
  endtask

  task automatic idle(input string tag);
    tick(tag, 0, '0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_step(input string tag);
    tick(tag, 0, '0, 0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_en[i] = 0; m_pend[i] = 0; end
    m_run = 0; m_step = 0; m_last = N - 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset");
    idle("R1 idle");

    // R4: start without run bit is ignored
    tick("R4 start no run", 0, '0, 0, 0, 0, 0, 1, 0);
    tick("R2 fill", 1, 16'hA5A5, 0, 0, 0, 0, 0, 0);
    do_step("R4 step unarmed");
    idle("R4 idle");

    // R4/R5/R6: normal run with back-to-back and spaced steps
    tick("R4 run_set", 0, '0, 0, 0, 1, 0, 0, 0);
    tick("R4 start", 0, '0, 0, 0, 0, 0, 1, 0);
    do_step("R5 s1"); do_step("R6 s2"); idle("R5 gap");
    // R8: writes during a run are ignored
    tick("R8 fill busy", 1, 16'hFFFF, 0, 0, 0, 0, 0, 0);
    tick("R8 last busy", 0, '0, 1, 2, 0, 0, 0, 0);
    for (int k = 0; k < 8; k++) begin do_step("R6 run"); idle("R10 gap"); end
    // R7: step after finish gives nothing
    do_step("R7 step done"); do_step("R7 step done2");

    // R9: restart
    tick("R9 restart", 0, '0, 0, 0, 0, 0, 1, 0);
    for (int k = 0; k < 10; k++) do_step("R9 run");

    // R3/R2: boundary limits fill
    tick("R3 last=3", 0, '0, 1, 3, 0, 0, 0, 0);
    tick("R2 fill bounded", 1, 16'hFFFF, 0, 0, 0, 0, 0, 0);
    tick("R9 start", 0, '0, 0, 0, 0, 0, 1, 0);
    for (int k = 0; k < 11; k++) do_step("R2 run");

    // R6: long skip across disabled links
    tick("R3 last=15", 0, '0, 1, 15, 0, 0, 0, 0);
    tick("R2 fill sparse", 1, 16'h8001, 0, 0, 0, 0, 0, 0);
    tick("R9 start2", 0, '0, 0, 0, 0, 0, 1, 0);
    do_step("R6 first"); do_step("R6 long skip"); do_step("R7 end");

    // R5: start wins over a firing step; R4: run_clr stops strobes
    tick("R9 start3", 0, '0, 0, 0, 0, 0, 1, 0);
    do_step("R5 fire");
    tick("R5 start+fire", 0, '0, 0, 0, 0, 0, 1, 1);
    tick("R4 run_clr", 0, '0, 0, 0, 0, 1, 0, 0);
    do_step("R4 stopped");
    tick("R8 fill idle", 1, 16'h0000, 0, 0, 0, 0, 0, 0);
    tick("R4 run_set+clr", 0, '0, 0, 0, 1, 1, 0, 0);
    do_step("R7 empty");
    idle("end");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule